// File: doc/BRIEF.md
# Seeded XOR Ring Load Generator

This block is a parameterised load generator. Its purpose is to fill a device with flip-flops and small logic functions that switch constantly, so that the fabric, the clock tree and the power rails can be stressed. The core is a closed ring of `NUM_CELLS` single-bit cells. On every clock edge each cell loads the XOR of the three cells that sit before it on the ring. Indices that fall below zero wrap around to the end of the ring.

A ring that is all zero would stay all zero forever. To prevent this, one extra flip-flop inverts itself on every edge, and its value is folded into the update of cell 0. This pushes the ring out of the zero state after reset, and the ring then runs as a pseudo-random pattern. A single output bit depends on the ring, so that a synthesis tool cannot remove any of it. The output is meant to go to an unused pin or an indicator. The only other ports are the clock and an active-low asynchronous reset. If the device powers its flip-flops up at zero, the reset may be tied high.

Top module: `xring_stress`

## Requirements
- R1: While `rst_n` is low, every ring cell and the starter flip-flop are 0 and `out_o` is 0. Asserting `rst_n` clears them at once, without waiting for a clock edge.
- R2: On every rising edge with `rst_n` high, the starter flip-flop inverts. On the first edge after reset is released it becomes 1, and because the ring is still all zero, `out_o` reads 1 after that edge.
- R3: On each rising edge out of reset, cell 0 loads the XOR of four values: the starter bit and cells `NUM_CELLS-1`, `NUM_CELLS-2` and `NUM_CELLS-3`, all as they were before the edge.
- R4: On each rising edge out of reset, every cell `i` from 1 to `NUM_CELLS-1` loads the XOR of cells `i-1`, `i-2` and `i-3`, all as they were before the edge. Negative indices wrap modulo `NUM_CELLS`.
- R5: `out_o` is the XOR of the last cell (index `NUM_CELLS-1`) and the starter bit. It is combinational and follows the state within the same cycle.
- R6: The sequence that follows a reset is fully determined. After a reset taken in the middle of a run, `out_o` repeats, edge for edge, the same sequence it produced after the first reset.
- R7: `NUM_CELLS` must be at least 3, and a smaller value is rejected at elaboration. The smallest legal ring of 3 cells follows R3 to R5 exactly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state updates on its rising edge |
| rst_n | input | 1 | Active-low asynchronous clear of the ring and the starter |
| out_o | output | 1 | Keep-alive bit: last ring cell XOR starter bit |

## Verification
The recurrence checks assume that `rst_n` changes only away from the rising clock edge. They also assume that the clock keeps running while reset is low, so that "previous edge" always refers to a defined, cleared state. The stimulus meets both assumptions. It raises and drops reset only at falling edges, or a few time units after them. It keeps reset low for at least one full rising edge, and it picks the run lengths and reset points from a fixed-seed random source. The bench predicts `out_o` for rings of 3, 7 and 32 cells with a model of its own.

// File: rtl/xring_pkg.sv
package xring_pkg;

  // Smallest ring in which every cell has three distinct predecessors.
  localparam int unsigned MIN_CELLS = 3;

  // Index of the cell `back` places before cell `idx` on a ring of `n`.
  function automatic int unsigned ring_prev(input int unsigned idx,
                                            input int unsigned back,
                                            input int unsigned n);
    return (idx + n - back) % n;
  endfunction

endpackage

// File: rtl/xring_starter.sv
// Free-running toggle that kicks the ring out of the all-zero state.
module xring_starter (
  input  logic clk,
  input  logic rst_n,
  output logic q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= ~q;
  end
endmodule

// File: rtl/xring_cell.sv
// One ring element: a flip-flop loading the XOR of three taps,
// optionally with the starter bit folded in.
module xring_cell #(
  parameter bit USE_SEED = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] taps,
  input  logic       seed,
  output logic       q
);
  logic nxt;

  generate
    if (USE_SEED) begin : g_seeded
      assign nxt = ^taps ^ seed;
    end else begin : g_plain
      logic unused_seed;
      assign unused_seed = seed;
      assign nxt = ^taps;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= nxt;
  end
endmodule

// File: rtl/xring_tap.sv
// Keep-alive output: depends on the ring and the starter.
module xring_tap (
  input  logic last_cell,
  input  logic seed,
  output logic tap
);
  assign tap = last_cell ^ seed;
endmodule

// File: rtl/xring_stress.sv
module xring_stress #(
  parameter int unsigned NUM_CELLS = 32
) (
  input  logic clk,
  input  logic rst_n,
  output logic out_o
);
  import xring_pkg::*;

  localparam int unsigned LAST = NUM_CELLS - 1;

  logic [NUM_CELLS-1:0] ring_q;
  logic                 seed_q;

  xring_starter u_starter (
    .clk   (clk),
    .rst_n (rst_n),
    .q     (seed_q)
  );

  generate
    for (genvar i = 0; i < NUM_CELLS; i++) begin : g_cell
      localparam int unsigned P1 = ring_prev(i, 1, NUM_CELLS);
      localparam int unsigned P2 = ring_prev(i, 2, NUM_CELLS);
      localparam int unsigned P3 = ring_prev(i, 3, NUM_CELLS);
      xring_cell #(
        .USE_SEED (i == 0)
      ) u_cell (
        .clk   (clk),
        .rst_n (rst_n),
        .taps  ({ring_q[P3], ring_q[P2], ring_q[P1]}),
        .seed  (seed_q),
        .q     (ring_q[i])
      );
    end
  endgenerate

  xring_tap u_tap (
    .last_cell (ring_q[LAST]),
    .seed      (seed_q),
    .tap       (out_o)
  );
endmodule

// File: rtl/xring_stress_chk.sv
module xring_stress_chk #(
  parameter int unsigned NUM_CELLS = 32
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NUM_CELLS-1:0] ring,
  input logic                 seed,
  input logic                 out_o
);
  import xring_pkg::*;

  localparam int unsigned LAST = NUM_CELLS - 1;

  // R7: ring too small to give each cell three predecessors
  initial begin
    a_r7_min_cells: assert (NUM_CELLS >= MIN_CELLS);
  end

  logic armed;
  always_ff @(posedge clk) armed <= 1'b1;

  // R1: held reset leaves everything cleared
  a_r1_reset_clear: assert property (@(posedge clk)
    (armed && $past(!rst_n) && !rst_n) |-> (ring == '0 && !seed && !out_o));

  // R2: starter inverts on every edge out of reset
  a_r2_starter_flip: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(rst_n)) |-> (seed != $past(seed)));

  // R3: cell 0 folds in the starter
  a_r3_cell0_seeded: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(rst_n)) |->
      (ring[0] == $past(seed ^ ring[LAST] ^ ring[LAST-1] ^ ring[LAST-2])));

  // R4: remaining cells follow the three predecessors
  generate
    for (genvar i = 1; i < NUM_CELLS; i++) begin : g_chk
      localparam int unsigned P1 = ring_prev(i, 1, NUM_CELLS);
      localparam int unsigned P2 = ring_prev(i, 2, NUM_CELLS);
      localparam int unsigned P3 = ring_prev(i, 3, NUM_CELLS);
      a_r4_cell_xor: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(rst_n)) |->
          (ring[i] == $past(ring[P1] ^ ring[P2] ^ ring[P3])));
    end
  endgenerate
endmodule

bind xring_stress xring_stress_chk #(.NUM_CELLS(NUM_CELLS)) u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .ring  (ring_q),
  .seed  (seed_q),
  .out_o (out_o)
);

// File: tb/tb_xring_stress.sv
module tb_xring_stress;
  localparam int CLK_PERIOD = 10;
  localparam int SEQ_LEN    = 40;
  localparam int N_A        = 32;
  localparam int N_B        = 7;
  localparam int N_C        = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic out_a, out_b, out_c;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  xring_stress #(.NUM_CELLS(N_A)) dut   (.clk(clk), .rst_n(rst_n), .out_o(out_a));
  xring_stress #(.NUM_CELLS(N_B)) dut_b (.clk(clk), .rst_n(rst_n), .out_o(out_b));
  xring_stress #(.NUM_CELLS(N_C)) dut_c (.clk(clk), .rst_n(rst_n), .out_o(out_c));

  // Reference model state, one slot per ring size
  logic [31:0] m_c [3];
  logic        m_t [3];
  logic        first_seq [SEQ_LEN];

  function automatic int size_of(input int k);
    return (k == 0) ? N_A : (k == 1) ? N_B : N_C;
  endfunction

  function automatic logic [31:0] ring_next(input logic [31:0] c, input logic t, input int n);
    logic [31:0] r;
    r = '0;
    for (int i = 0; i < n; i++) begin
      r[i] = c[(i+n-1)%n] ^ c[(i+n-2)%n] ^ c[(i+n-3)%n];
      if (i == 0) r[i] = r[i] ^ t;
    end
    return r;
  endfunction

  function automatic logic model_out(input int k);
    return m_c[k][size_of(k)-1] ^ m_t[k];
  endfunction

  function automatic logic dut_out(input int k);
    return (k == 0) ? out_a : (k == 1) ? out_b : out_c;
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_clear();
    for (int k = 0; k < 3; k++) begin
      m_c[k] = '0;
      m_t[k] = 1'b0;
    end
  endtask

  // One clock: model follows the edge, outputs compared at the falling edge.
  task automatic step();
    @(posedge clk);
    for (int k = 0; k < 3; k++) begin
      if (rst_n) begin
        m_c[k] = ring_next(m_c[k], m_t[k], size_of(k));
        m_t[k] = ~m_t[k];
      end else begin
        m_c[k] = '0;
        m_t[k] = 1'b0;
      end
    end
    @(negedge clk);
    check("R3 R4 R5 ring of 32", out_a, model_out(0));
    check("R3 R4 R5 ring of 7",  out_b, model_out(1));
    check("R7 smallest ring of 3", out_c, model_out(2));
  endtask

  task automatic release_and_check_first();
    rst_n = 1'b1;
    step();
    for (int k = 0; k < 3; k++) check("R2 first edge after release", dut_out(k), 1'b1);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int unsigned junk;
    junk = $urandom(32'h0c0ffee5);
    model_clear();
    rst_n = 1'b0;
    // R1: held reset
    repeat (3) begin
      step();
      for (int k = 0; k < 3; k++) check("R1 held reset", dut_out(k), 1'b0);
    end
    release_and_check_first();
    first_seq[0] = out_a;
    for (int i = 1; i < SEQ_LEN; i++) begin
      step();
      first_seq[i] = out_a;
    end

    for (int burst = 0; burst < 8; burst++) begin
      int run_len;
      int hold;
      int skew;
      run_len = 50 + int'($urandom_range(350));
      hold    = 1 + int'($urandom_range(2));
      skew    = 1 + int'($urandom_range(3));
      repeat (run_len) step();
      // R1: asynchronous clear between edges
      #(skew);
      rst_n = 1'b0;
      #1;
      model_clear();
      for (int k = 0; k < 3; k++) check("R1 async clear", dut_out(k), 1'b0);
      @(negedge clk);
      repeat (hold) begin
        step();
        for (int k = 0; k < 3; k++) check("R1 held reset", dut_out(k), 1'b0);
      end
      release_and_check_first();
      check("R6 restart sequence", out_a, first_seq[0]);
      for (int i = 1; i < SEQ_LEN; i++) begin
        step();
        check("R6 restart sequence", out_a, first_seq[i]);
      end
    end

    repeat (500) step();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule